// File: doc/BRIEF.md
# Port Control-Line Interrupt and Handshake Unit

This unit serves the two control lines of one parallel port. The first line is only an input. A programmable transition on it sets an interrupt flag. The second line is either a second interrupt input or an output. As an output it can give a one-cycle strobe, an interlocked handshake, or a fixed level. Both flags can be enabled onto an active-low interrupt request. A read of the port data register clears both flags.

A host register block owns the control register bits and the port data register. It passes those bits to this unit, together with one-cycle read and write strobes for the data register. The parameter `TX_SIDE` selects the side of the port. On a receive port (`TX_SIDE=0`), data reads start the strobe and the handshake. On a transmit port (`TX_SIDE=1`), data writes start them. Both control inputs pass through a synchroniser before edge detection.

The second line is driven by a state machine with six states:
- `L2_INPUT`: the line is an input.
- `L2_STATIC`: the line drives a fixed level.
- `L2_PULSE_IDLE` and `L2_PULSE_LOW`: strobe mode, waiting or driving the strobe.
- `L2_HS_READY` and `L2_HS_WAIT`: handshake mode, line high or line held low.

The transitions are as follows:
- Change-of-mode: whenever the decoded mode differs from the current state's mode, the machine moves to that mode's resting state.
- Strobe-fire: `L2_PULSE_IDLE` or `L2_PULSE_LOW` moves to `L2_PULSE_LOW` on a triggering access.
- Strobe-end: `L2_PULSE_LOW` moves to `L2_PULSE_IDLE` when no triggering access occurs.
- Handshake-request: `L2_HS_READY` moves to `L2_HS_WAIT` on a triggering access.
- Handshake-release: `L2_HS_WAIT` moves to `L2_HS_READY` on an active first-line edge. A triggering access in the same cycle takes priority and keeps the line low.

Top module: `ctl_line_unit`

## Requirements
- R1: After reset, both flags read 0, `irq_n` is 1 and `line2_oe` is 0.
- R2: An active transition on `line1_in` sets `flag1`, three clock edges after the input is first sampled. `edge1_rise` selects the active transition: 1 means rising (register bit 1), 0 means falling. The other transition leaves `flag1` unchanged.
- R3: When `l2_ctl[2]` (register bit 5) is 0, the second line is an input and `line2_oe` is 0. The transition chosen by `l2_ctl[1]` (bit 4, 1 means rising) sets `flag2`. The other transition does not set it.
- R4: `irq_n` is 0 exactly when either of two conditions holds:
  - `flag1` and `irq1_en` (bit 0) are both 1;
  - `flag2` and `l2_ctl[0]` (bit 3) are both 1 and `l2_ctl[2]` is 0.
- R5: A `data_rd` strobe clears both flags on the next clock edge, unless an active edge on the same cycle sets the flag again.
- R6: Strobe mode is `l2_ctl` = 3'b101. Each triggering access drives `line2_out` low for exactly the following cycle. Consecutive accesses keep the line low. On the receive side the triggering access is `data_rd`; on the transmit side it is `data_wr`.
- R7: Handshake mode is `l2_ctl` = 3'b100. A triggering access drives `line2_out` low, and it stays low until the next active `line1_in` transition is detected. An inactive transition does not release it.
- R8: Static mode is `l2_ctl[2:1]` = 2'b11. `line2_out` equals `l2_ctl[0]` and `line2_oe` is 1.
- R9: The access type that does not trigger for the configured side has no effect on `line2_out`.
- R10: While `l2_ctl[2]` is 1, `flag2` stays 0, and transitions on `line2_in` do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq1_en | input | 1 | Enables flag1 onto the request (register bit 0) |
| edge1_rise | input | 1 | First-line active transition: 1 rising, 0 falling (bit 1) |
| l2_ctl | input | 3 | Second-line control (bits 5..3) |
| data_rd | input | 1 | One-cycle strobe: host read of the port data register |
| data_wr | input | 1 | One-cycle strobe: host write of the port data register |
| line1_in | input | 1 | First control line (asynchronous input) |
| line2_in | input | 1 | Second control line input value (asynchronous) |
| line2_out | output | 1 | Second control line output value |
| line2_oe | output | 1 | Output enable for the second control line |
| flag1 | output | 1 | First-line interrupt flag (register bit 7) |
| flag2 | output | 1 | Second-line interrupt flag (register bit 6) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The checker watches the following on every cycle:
- a low strobe is always traced back to a triggering access;
- a held handshake line stays low until a first-line edge arrives;
- the static level follows its control bit;
- flag1 only rises after a detected active edge;
- a data read clears flag1;
- flag2 stays clear in output modes;
- a low request always has a flag behind it.

Other properties need the bench's scenarios:
- the three-edge synchroniser latency;
- the choice between rising and falling edges;
- inactive edges being ignored;
- the interrupt mask combinations;
- the difference between the receive and transmit sides. The bench shows this by driving the same strobes into both variants at once.

// File: rtl/ctl_line_pkg.sv
package ctl_line_pkg;

    typedef enum logic [2:0] {
        L2_INPUT,
        L2_STATIC,
        L2_PULSE_IDLE,
        L2_PULSE_LOW,
        L2_HS_READY,
        L2_HS_WAIT
    } l2_state_e;

    typedef enum logic [1:0] {
        MD_INPUT,
        MD_STATIC,
        MD_PULSE,
        MD_HANDSHAKE
    } l2_mode_e;

    // l2_ctl[2] = output select, [1] = static/edge select, [0] = level/enable
    function automatic l2_mode_e decode_mode(input logic [2:0] c);
        if (!c[2])     return MD_INPUT;
        else if (c[1]) return MD_STATIC;
        else if (c[0]) return MD_PULSE;
        else           return MD_HANDSHAKE;
    endfunction

    function automatic l2_mode_e mode_of(input l2_state_e s);
        unique case (s)
            L2_INPUT:                   return MD_INPUT;
            L2_STATIC:                  return MD_STATIC;
            L2_PULSE_IDLE, L2_PULSE_LOW: return MD_PULSE;
            default:                    return MD_HANDSHAKE;
        endcase
    endfunction

    function automatic l2_state_e rest_of(input l2_mode_e m);
        unique case (m)
            MD_INPUT:  return L2_INPUT;
            MD_STATIC: return L2_STATIC;
            MD_PULSE:  return L2_PULSE_IDLE;
            default:   return L2_HS_READY;
        endcase
    endfunction

endpackage

// File: rtl/ctl_sync_edge.sv
module ctl_sync_edge #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;
    logic         prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= IDLE;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{IDLE}};
                else        chain_q <= {chain_q[TOP-1:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= chain_q[TOP];
    end

    assign rise = chain_q[TOP] & ~prev_q;
    assign fall = ~chain_q[TOP] & prev_q;
endmodule

// File: rtl/ctl_line2_fsm.sv
module ctl_line2_fsm
    import ctl_line_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] l2_ctl,
    input  logic       acc,
    input  logic       act1,
    output logic       line2_out,
    output logic       line2_oe
);
    l2_state_e state_q, state_d;
    l2_mode_e  mode;

    assign mode = decode_mode(l2_ctl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= L2_INPUT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mode_of(state_q) != mode) begin
            state_d = rest_of(mode);
        end else begin
            unique case (state_q)
                L2_INPUT:      state_d = L2_INPUT;
                L2_STATIC:     state_d = L2_STATIC;
                L2_PULSE_IDLE: state_d = acc ? L2_PULSE_LOW : L2_PULSE_IDLE;
                L2_PULSE_LOW:  state_d = acc ? L2_PULSE_LOW : L2_PULSE_IDLE;
                L2_HS_READY:   state_d = acc ? L2_HS_WAIT : L2_HS_READY;
                L2_HS_WAIT: begin
                    if (acc)       state_d = L2_HS_WAIT;
                    else if (act1) state_d = L2_HS_READY;
                    else           state_d = L2_HS_WAIT;
                end
                default:       state_d = L2_INPUT;
            endcase
        end
    end

    always_comb begin
        line2_oe = l2_ctl[2];
        unique case (state_q)
            L2_STATIC:                 line2_out = l2_ctl[0];
            L2_PULSE_LOW, L2_HS_WAIT:  line2_out = 1'b0;
            default:                   line2_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/ctl_line_unit.sv
module ctl_line_unit #(
    parameter bit TX_SIDE     = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq1_en,
    input  logic       edge1_rise,
    input  logic [2:0] l2_ctl,
    input  logic       data_rd,
    input  logic       data_wr,
    input  logic       line1_in,
    input  logic       line2_in,
    output logic       line2_out,
    output logic       line2_oe,
    output logic       flag1,
    output logic       flag2,
    output logic       irq_n
);
    logic rise1, fall1, rise2, fall2;
    logic act1, act2, acc;
    logic flag1_q, flag2_q;

    ctl_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync1 (
        .clk(clk), .rst_n(rst_n), .din(line1_in), .rise(rise1), .fall(fall1)
    );

    ctl_sync_edge #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync2 (
        .clk(clk), .rst_n(rst_n), .din(line2_in), .rise(rise2), .fall(fall2)
    );

    assign act1 = edge1_rise ? rise1 : fall1;
    assign act2 = l2_ctl[1] ? rise2 : fall2;

    generate
        if (TX_SIDE) begin : g_tx
            assign acc = data_wr;
        end else begin : g_rx
            assign acc = data_rd;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag1_q <= 1'b0;
            flag2_q <= 1'b0;
        end else begin
            if (act1)         flag1_q <= 1'b1;
            else if (data_rd) flag1_q <= 1'b0;

            if (l2_ctl[2])    flag2_q <= 1'b0;
            else if (act2)    flag2_q <= 1'b1;
            else if (data_rd) flag2_q <= 1'b0;
        end
    end

    ctl_line2_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .l2_ctl(l2_ctl), .acc(acc), .act1(act1),
        .line2_out(line2_out), .line2_oe(line2_oe)
    );

    assign flag1 = flag1_q;
    assign flag2 = flag2_q;
    assign irq_n = ~((flag1_q & irq1_en) | (flag2_q & l2_ctl[0] & ~l2_ctl[2]));
endmodule

// File: rtl/ctl_line_chk.sv
module ctl_line_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] l2_ctl,
    input logic       data_rd,
    input logic       acc,
    input logic       act1,
    input logic       line2_out,
    input logic       flag1,
    input logic       flag2,
    input logic       irq_n
);
    logic pulse_md, hs_md, stat_md;
    assign pulse_md = (l2_ctl == 3'b101);
    assign hs_md    = (l2_ctl == 3'b100);
    assign stat_md  = l2_ctl[2] & l2_ctl[1];

    // R6
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_md && $past(pulse_md) && !line2_out) |-> $past(acc));

    // R7
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_md && $past(hs_md) && $past(hs_md, 2) && $past(!line2_out) && !$past(act1))
        |-> !line2_out);

    // R8
    static_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_md && $past(stat_md)) |-> (line2_out == l2_ctl[0]));

    // R2
    flag1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag1) |-> $past(act1));

    // R5
    flag1_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !act1) |=> !flag1);

    // R10
    flag2_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_ctl[2] |=> !flag2);

    // R4
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flag1 || flag2));
endmodule

bind ctl_line_unit ctl_line_chk chk_i (
    .clk(clk), .rst_n(rst_n), .l2_ctl(l2_ctl), .data_rd(data_rd), .acc(acc),
    .act1(act1), .line2_out(line2_out), .flag1(flag1), .flag2(flag2), .irq_n(irq_n)
);

// File: tb/ctl_line_unit_tb.sv
module ctl_line_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq1_en = 1'b0, edge1_rise = 1'b0;
    logic [2:0] l2_ctl = 3'b000;
    logic       data_rd = 1'b0, data_wr = 1'b0;
    logic       line1 = 1'b1, line2 = 1'b1;
    logic       rx_out, rx_oe, rx_f1, rx_f2, rx_irq;
    logic       tx_out, tx_oe, tx_f1, tx_f2, tx_irq;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ctl_line_unit #(.TX_SIDE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq1_en(irq1_en), .edge1_rise(edge1_rise),
        .l2_ctl(l2_ctl), .data_rd(data_rd), .data_wr(data_wr),
        .line1_in(line1), .line2_in(line2), .line2_out(rx_out), .line2_oe(rx_oe),
        .flag1(rx_f1), .flag2(rx_f2), .irq_n(rx_irq)
    );

    ctl_line_unit #(.TX_SIDE(1'b1)) dut_tx_i (
        .clk(clk), .rst_n(rst_n), .irq1_en(irq1_en), .edge1_rise(edge1_rise),
        .l2_ctl(l2_ctl), .data_rd(data_rd), .data_wr(data_wr),
        .line1_in(line1), .line2_in(line2), .line2_out(tx_out), .line2_oe(tx_oe),
        .flag1(tx_f1), .flag2(tx_f2), .irq_n(tx_irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // c[0]=irq1_en c[1]=edge1_rise c[5:3]=l2_ctl
    task automatic set_ctl(input logic [5:0] c);
        irq1_en = c[0];
        edge1_rise = c[1];
        l2_ctl = c[5:3];
    endtask

    task automatic rd_clear();
        data_rd = 1'b1; tick(1); data_rd = 1'b0; tick(1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        tick(3);
        chk("R1", "flag1", rx_f1, 1'b0);
        chk("R1", "flag2", rx_f2, 1'b0);
        chk("R1", "irq_n", rx_irq, 1'b1);
        chk("R1", "oe", rx_oe, 1'b0);
        rst_n = 1'b1;
        tick(2);

        // R2 / R4 / R5: both polarities, both transitions, enabled and masked
        for (int pol = 0; pol < 2; pol++) begin
            for (int en = 0; en < 2; en++) begin
                set_ctl({3'b000, 1'b0, pol[0], en[0]});
                tick(1);
                for (int step = 0; step < 2; step++) begin
                    logic nv, ex;
                    nv = step[0];
                    ex = (nv == pol[0]);
                    line1 = nv;
                    tick(3);
                    chk("R2", "flag1 after edge", rx_f1, ex);
                    chk("R4", "irq_n line1", rx_irq, !(ex && en[0]));
                    rd_clear();
                    chk("R5", "flag1 cleared", rx_f1, 1'b0);
                    chk("R5", "irq_n cleared", rx_irq, 1'b1);
                end
            end
        end

        // R3 / R4: second line as input, both polarities and enables
        for (int pol = 0; pol < 2; pol++) begin
            for (int en = 0; en < 2; en++) begin
                set_ctl({1'b0, pol[0], en[0], 3'b000});
                tick(1);
                chk("R3", "oe in input mode", rx_oe, 1'b0);
                for (int step = 0; step < 2; step++) begin
                    logic nv, ex;
                    nv = step[0];
                    ex = (nv == pol[0]);
                    line2 = nv;
                    tick(3);
                    chk("R3", "flag2 after edge", rx_f2, ex);
                    chk("R4", "irq_n line2", rx_irq, !(ex && en[0]));
                    rd_clear();
                    chk("R5", "flag2 cleared", rx_f2, 1'b0);
                end
            end
        end

        // R10: flag2 cleared and held in output mode
        set_ctl(6'b011000);
        line2 = 1'b0; tick(3); line2 = 1'b1; tick(3);
        chk("R3", "flag2 set before mode change", rx_f2, 1'b1);
        set_ctl(6'b111000);
        tick(1);
        chk("R10", "flag2 cleared by output mode", rx_f2, 1'b0);
        line2 = 1'b0; tick(3); line2 = 1'b1; tick(3);
        chk("R10", "flag2 held in output mode", rx_f2, 1'b0);

        // R8: static levels
        for (int lv = 0; lv < 2; lv++) begin
            set_ctl({2'b11, lv[0], 3'b000});
            tick(2);
            chk("R8", "rx static level", rx_out, lv[0]);
            chk("R8", "tx static level", tx_out, lv[0]);
            chk("R8", "oe static", rx_oe, 1'b1);
        end

        // R6 / R9: strobe mode
        set_ctl(6'b101000);
        tick(2);
        chk("R6", "rx strobe idle", rx_out, 1'b1);
        data_rd = 1'b1; tick(1); data_rd = 1'b0;
        chk("R6", "rx strobe on read", rx_out, 1'b0);
        chk("R9", "tx ignores read", tx_out, 1'b1);
        tick(1);
        chk("R6", "rx strobe one cycle", rx_out, 1'b1);
        data_wr = 1'b1; tick(1); data_wr = 1'b0;
        chk("R6", "tx strobe on write", tx_out, 1'b0);
        chk("R9", "rx ignores write", rx_out, 1'b1);
        tick(1);
        chk("R6", "tx strobe one cycle", tx_out, 1'b1);
        data_rd = 1'b1; tick(1);
        chk("R6", "rx back-to-back 1", rx_out, 1'b0);
        tick(1); data_rd = 1'b0;
        chk("R6", "rx back-to-back 2", rx_out, 1'b0);
        tick(1);
        chk("R6", "rx strobe ends", rx_out, 1'b1);

        // R7 / R9: handshake with rising active edge on line1
        set_ctl(6'b100010);
        tick(2);
        chk("R7", "rx handshake idle high", rx_out, 1'b1);
        data_rd = 1'b1; tick(1); data_rd = 1'b0;
        chk("R7", "rx low after read", rx_out, 1'b0);
        chk("R9", "tx ignores read", tx_out, 1'b1);
        data_wr = 1'b1; tick(1); data_wr = 1'b0;
        chk("R7", "tx low after write", tx_out, 1'b0);
        tick(5);
        chk("R7", "rx held low", rx_out, 1'b0);
        chk("R7", "tx held low", tx_out, 1'b0);
        line1 = 1'b0; tick(3);
        chk("R7", "rx inactive edge keeps low", rx_out, 1'b0);
        line1 = 1'b1; tick(3);
        chk("R7", "rx released by edge", rx_out, 1'b1);
        chk("R7", "tx released by edge", tx_out, 1'b1);
        chk("R2", "flag1 from handshake edge", rx_f1, 1'b1);

        done = 1'b1;
        summary();
    end
endmodule